// File: doc/BRIEF.md
# Instruction Queue Trace Reconstructor

This block sits beside a processor and listens passively to three things: the bus clock E, a two-bit queue-status pair and the 16-bit data bus. The status pair carries two unrelated meanings depending on the E edge. On the rising edge it says how words move through the processor's prefetch queue. On the falling edge it says whether an instruction, or an interrupt sequence, starts executing. From this the block rebuilds a shadow copy of the prefetch queue: a holding latch and two queue stages. Each time execution starts, it reports the opcode byte that the processor is about to run.

All inputs pass through a two-flop synchronizer into a fast system clock domain. E edges are found by comparing successive synchronized samples. At every falling edge the bus word is captured, because the movement code that arrives on the following rising edge refers to that word. Each start produces one single-cycle event on the output. The event carries the opcode, a flag for odd alignment and a flag for interrupts. A start that finds no valid data at the head of the queue raises a one-cycle error pulse instead.

Top module: `queue_trace`

## Requirements
- R1: E, the status pair and the bus pass through the same synchronizer depth, so every E edge is acted on exactly once when each E half period lasts at least four system clocks; every start presented on the pins yields exactly one output event.
- R2: Movement code 01, sampled at an E rising edge, copies the bus word captured at the preceding E falling edge into the holding latch and marks the latch valid.
- R3: Movement code 10 at an E rising edge shifts stage 2 (with its valid bit) into stage 1, writes the word captured at the preceding falling edge into stage 2 and marks stage 2 valid.
- R4: Movement code 11 at an E rising edge shifts stage 2 into stage 1 and writes the holding latch (with its valid bit) into stage 2.
- R5: Code 00 on either edge changes no queue state and emits no event.
- R6: Start code 10 at an E falling edge with a valid stage 1 emits evtValid with evtOpcode equal to bits [15:8] of stage 1 and evtOdd = 0.
- R7: Start code 11 at an E falling edge with a valid stage 1 emits evtValid with evtOpcode equal to bits [7:0] of stage 1 and evtOdd = 1.
- R8: Start code 01 emits evtValid with evtIrq = 1, evtOdd = 0 and evtOpcode = 0x00, whatever the queue holds.
- R9: Start code 10 or 11 while stage 1 is invalid emits a one-cycle evtErr and no evtValid.
- R10: A synchronous active-high reset clears the latch and both stages, marks them invalid and holds evtValid and evtErr low.
- R11: evtValid and evtErr are never high together, and each is high for one system clock per start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the E frequency |
| rst | input | 1 | Synchronous active-high reset |
| eClk | input | 1 | Processor bus clock E (asynchronous) |
| pipeStat | input | 2 | Time-multiplexed queue status pair |
| busData | input | 16 | Processor data bus |
| evtValid | output | 1 | One-cycle strobe for an execution start |
| evtOpcode | output | 8 | Opcode byte of the started instruction |
| evtOdd | output | 1 | Start was odd-aligned (low byte) |
| evtIrq | output | 1 | Start was an interrupt sequence |
| evtErr | output | 1 | One-cycle pulse: start seen with an empty queue head |

## Verification
The hardest case to reach is an advance from the latch in which the latch word was captured several E cycles earlier and the head is then read by an odd start. It needs a latch load, bus advances that fill both stages, and the latch-sourced word shifted to the head before the start. A directed script builds exactly that sequence. It also covers a start on an empty queue and a reset in the middle of a run. Long random runs of movement and start codes then mix latch reuse and empty-queue starts, and a bench model predicts every event.

// File: rtl/qtrace_pkg.sv
package qtrace_pkg;

  typedef enum logic [1:0] {
    MV_HOLD      = 2'b00,
    MV_LATCH     = 2'b01,
    MV_ADV_BUS   = 2'b10,
    MV_ADV_LATCH = 2'b11
  } moveCode_e;

  typedef enum logic [1:0] {
    ST_NONE = 2'b00,
    ST_IRQ  = 2'b01,
    ST_EVEN = 2'b10,
    ST_ODD  = 2'b11
  } startCode_e;

  // strobes from control to datapath, each valid for one system clock
  typedef struct packed {
    logic capture;   // falling E: take bus word
    logic latchLoad; // rising E, code 01
    logic advBus;    // rising E, code 10
    logic advLatch;  // rising E, code 11
    logic startIrq;  // falling E, code 01
    logic startEven; // falling E, code 10
    logic startOdd;  // falling E, code 11
  } qStrobe_t;

endpackage

// File: rtl/qtrace_sync.sv
module qtrace_sync #(
  parameter int WIDTH  = 19,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/qtrace_ctrl.sv
module qtrace_ctrl
  import qtrace_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       eSync,
  input  logic [1:0] statSync,
  output qStrobe_t   strb
);

  logic       prevE;
  logic       eRise;
  logic       eFall;
  moveCode_e  moveCode;
  startCode_e startCode;

  always_ff @(posedge clk) begin
    if (rst) prevE <= 1'b0;
    else     prevE <= eSync;
  end

  assign eRise     = eSync & ~prevE;
  assign eFall     = ~eSync & prevE;
  assign moveCode  = moveCode_e'(statSync);
  assign startCode = startCode_e'(statSync);

  always_comb begin
    strb = '0;
    if (eRise) begin
      unique case (moveCode)
        MV_LATCH:     strb.latchLoad = 1'b1;
        MV_ADV_BUS:   strb.advBus    = 1'b1;
        MV_ADV_LATCH: strb.advLatch  = 1'b1;
        default:      ;
      endcase
    end
    if (eFall) begin
      strb.capture = 1'b1;
      unique case (startCode)
        ST_IRQ:  strb.startIrq  = 1'b1;
        ST_EVEN: strb.startEven = 1'b1;
        ST_ODD:  strb.startOdd  = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/qtrace_dp.sv
module qtrace_dp
  import qtrace_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int OP_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  qStrobe_t          strb,
  input  logic [WORD_W-1:0] busSync,
  output logic [WORD_W-1:0] capWord,
  output logic [WORD_W-1:0] latchWord,
  output logic              latchValid,
  output logic [WORD_W-1:0] headWord,
  output logic              headValid,
  output logic [WORD_W-1:0] tailWord,
  output logic              tailValid,
  output logic              evtValid,
  output logic [OP_W-1:0]   evtOpcode,
  output logic              evtOdd,
  output logic              evtIrq,
  output logic              evtErr
);

  logic              doAdvance;
  logic [WORD_W-1:0] newTail;
  logic              newTailValid;
  logic [OP_W-1:0]   headByte;

  assign doAdvance    = strb.advBus | strb.advLatch;
  assign newTail      = strb.advLatch ? latchWord : capWord;
  assign newTailValid = strb.advLatch ? latchValid : 1'b1;
  assign headByte     = strb.startOdd ? headWord[OP_W-1:0] : headWord[WORD_W-1:OP_W];

  // queue model
  always_ff @(posedge clk) begin
    if (rst) begin
      capWord    <= '0;
      latchWord  <= '0;
      latchValid <= 1'b0;
      headWord   <= '0;
      headValid  <= 1'b0;
      tailWord   <= '0;
      tailValid  <= 1'b0;
    end else begin
      if (strb.capture) capWord <= busSync;
      if (strb.latchLoad) begin
        latchWord  <= capWord;
        latchValid <= 1'b1;
      end
      if (doAdvance) begin
        headWord  <= tailWord;
        headValid <= tailValid;
        tailWord  <= newTail;
        tailValid <= newTailValid;
      end
    end
  end

  // event formatter
  always_ff @(posedge clk) begin
    if (rst) begin
      evtValid  <= 1'b0;
      evtOpcode <= '0;
      evtOdd    <= 1'b0;
      evtIrq    <= 1'b0;
      evtErr    <= 1'b0;
    end else begin
      evtValid  <= 1'b0;
      evtOpcode <= '0;
      evtOdd    <= 1'b0;
      evtIrq    <= 1'b0;
      evtErr    <= 1'b0;
      if (strb.startIrq) begin
        evtValid <= 1'b1;
        evtIrq   <= 1'b1;
      end else if (strb.startEven | strb.startOdd) begin
        if (headValid) begin
          evtValid  <= 1'b1;
          evtOpcode <= headByte;
          evtOdd    <= strb.startOdd;
        end else begin
          evtErr <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/queue_trace.sv
module queue_trace
  import qtrace_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int OP_W   = WORD_W / 2,
  localparam int PACK_W = WORD_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eClk,
  input  logic [1:0]        pipeStat,
  input  logic [WORD_W-1:0] busData,
  output logic              evtValid,
  output logic [OP_W-1:0]   evtOpcode,
  output logic              evtOdd,
  output logic              evtIrq,
  output logic              evtErr
);

  logic [PACK_W-1:0] rawIn;
  logic [PACK_W-1:0] syncIn;
  logic              eSync;
  logic [1:0]        statSync;
  logic [WORD_W-1:0] busSync;
  qStrobe_t          strb;
  logic [WORD_W-1:0] capWord, latchWord, headWord, tailWord;
  logic              latchValid, headValid, tailValid;

  assign rawIn = {eClk, pipeStat, busData};

  qtrace_sync #(.WIDTH(PACK_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .asyncIn(rawIn), .syncOut(syncIn)
  );

  assign eSync    = syncIn[PACK_W-1];
  assign statSync = syncIn[WORD_W+1:WORD_W];
  assign busSync  = syncIn[WORD_W-1:0];

  qtrace_ctrl u_ctrl (
    .clk(clk), .rst(rst), .eSync(eSync), .statSync(statSync), .strb(strb)
  );

  qtrace_dp #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .busSync(busSync),
    .capWord(capWord), .latchWord(latchWord), .latchValid(latchValid),
    .headWord(headWord), .headValid(headValid),
    .tailWord(tailWord), .tailValid(tailValid),
    .evtValid(evtValid), .evtOpcode(evtOpcode), .evtOdd(evtOdd),
    .evtIrq(evtIrq), .evtErr(evtErr)
  );

endmodule

// File: rtl/qtrace_chk.sv
module qtrace_chk
  import qtrace_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int OP_W = WORD_W / 2
) (
  input logic              clk,
  input logic              rst,
  input qStrobe_t          strb,
  input logic [WORD_W-1:0] capWord,
  input logic [WORD_W-1:0] latchWord,
  input logic              latchValid,
  input logic [WORD_W-1:0] headWord,
  input logic              headValid,
  input logic [WORD_W-1:0] tailWord,
  input logic              tailValid,
  input logic              evtValid,
  input logic [OP_W-1:0]   evtOpcode,
  input logic              evtOdd,
  input logic              evtIrq,
  input logic              evtErr
);

  a_r2_latch_load: assert property (@(posedge clk) disable iff (rst)
    strb.latchLoad |=> latchValid && latchWord == $past(capWord));

  a_r3_adv_bus: assert property (@(posedge clk) disable iff (rst)
    strb.advBus |=> headWord == $past(tailWord) && tailWord == $past(capWord) && tailValid);

  a_r4_adv_latch: assert property (@(posedge clk) disable iff (rst)
    strb.advLatch |=> tailWord == $past(latchWord) && tailValid == $past(latchValid)
                      && headValid == $past(tailValid));

  a_r8_irq_fields: assert property (@(posedge clk) disable iff (rst)
    (evtValid && evtIrq) |-> (evtOpcode == '0 && !evtOdd));

  a_r9_err_empty: assert property (@(posedge clk) disable iff (rst)
    evtErr |-> !$past(headValid));

  a_r10_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!evtValid && !evtErr && !headValid && !tailValid && !latchValid));

  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(evtValid && evtErr));

  a_r11_single_valid: assert property (@(posedge clk) disable iff (rst)
    evtValid |=> !evtValid);

  a_r11_single_err: assert property (@(posedge clk) disable iff (rst)
    evtErr |=> !evtErr);

endmodule

bind queue_trace qtrace_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .strb(strb), .capWord(capWord),
  .latchWord(latchWord), .latchValid(latchValid),
  .headWord(headWord), .headValid(headValid),
  .tailWord(tailWord), .tailValid(tailValid),
  .evtValid(evtValid), .evtOpcode(evtOpcode), .evtOdd(evtOdd),
  .evtIrq(evtIrq), .evtErr(evtErr)
);

// File: tb/queue_trace_tb.sv
module queue_trace_tb;

  localparam int HALF = 8; // system clocks per E half period

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        eClk = 1'b0;
  logic [1:0]  pipeStat = 2'b00;
  logic [15:0] busData = '0;
  logic        evtValid, evtOdd, evtIrq, evtErr;
  logic [7:0]  evtOpcode;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // bench model of the queue
  logic [15:0] mCap, mLatch, mHead, mTail;
  logic        mLV, mHV, mTV;
  logic [10:0] expQ[$]; // {err, irq, odd, opcode}

  always #10 clk = ~clk; // 50 MHz

  queue_trace u_dut (
    .clk(clk), .rst(rst), .eClk(eClk), .pipeStat(pipeStat), .busData(busData),
    .evtValid(evtValid), .evtOpcode(evtOpcode), .evtOdd(evtOdd),
    .evtIrq(evtIrq), .evtErr(evtErr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] startExpect(input logic [1:0] s);
    if (s == 2'b01) return {3'b010, 8'h00};
    if (!mHV)       return {3'b100, 8'h00};
    if (s == 2'b11) return {3'b001, mHead[7:0]};
    return {3'b000, mHead[15:8]};
  endfunction

  task automatic modelReset();
    mCap = '0; mLatch = '0; mHead = '0; mTail = '0;
    mLV = 1'b0; mHV = 1'b0; mTV = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; eClk = 1'b0; pipeStat = 2'b00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    modelReset();
    @(negedge clk);
    check("R10 evtValid after reset", {31'd0, evtValid}, 32'd0);
    check("R10 evtErr after reset", {31'd0, evtErr}, 32'd0);
  endtask

  // one full E cycle: rising edge with a movement code, falling edge with a start code
  task automatic eCycle(input logic [1:0] mv, input logic [1:0] st, input logic [15:0] word);
    @(negedge clk);
    eClk = 1'b1; pipeStat = mv;
    case (mv)
      2'b01: begin mLatch = mCap; mLV = 1'b1; end
      2'b10: begin mHead = mTail; mHV = mTV; mTail = mCap; mTV = 1'b1; end
      2'b11: begin mHead = mTail; mHV = mTV; mTail = mLatch; mTV = mLV; end
      default: ;
    endcase
    repeat (HALF) @(negedge clk);
    eClk = 1'b0; pipeStat = st; busData = word;
    if (st != 2'b00) expQ.push_back(startExpect(st));
    mCap = word;
    repeat (HALF - 1) @(negedge clk);
  endtask

  // event monitor
  always @(negedge clk) begin
    if (!rst && (evtValid || evtErr)) begin
      logic [10:0] exp;
      string tag;
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R1 unexpected event actual=%h expected=none",
                 {evtErr, evtIrq, evtOdd, evtOpcode});
      end else begin
        exp = expQ.pop_front();
        tag = exp[10] ? "R9 empty-head error" : exp[9] ? "R8 interrupt start" :
              exp[8] ? "R7 odd start" : "R6 even start";
        check(tag, {21'd0, evtErr, evtIrq, evtOdd, evtOpcode}, {21'd0, exp});
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d cycles expected=finish", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0c0ffee5));
    modelReset();
    doReset();

    // R9: start with an empty queue
    eCycle(2'b00, 2'b10, 16'hA1B2);
    // R2: latch word A1B2 (captured at previous fall), capture 1122
    eCycle(2'b01, 2'b00, 16'h1122);
    // R3: two bus advances: tail=1122, then head=1122, tail=3344
    eCycle(2'b10, 2'b00, 16'h3344);
    eCycle(2'b10, 2'b10, 16'h5566);   // R6 even -> 0x11
    // R5: idle codes leave the head alone
    eCycle(2'b00, 2'b00, 16'h7788);
    eCycle(2'b00, 2'b11, 16'h99AA);   // R7 odd -> 0x22
    // R4: advance from latch: head=3344, tail=A1B2
    eCycle(2'b11, 2'b11, 16'hBBCC);   // odd -> 0x44
    eCycle(2'b10, 2'b10, 16'hDDEE);   // head=A1B2 -> 0xA1
    eCycle(2'b00, 2'b11, 16'h0F0F);   // latch-sourced word, odd -> 0xB2
    eCycle(2'b00, 2'b01, 16'hFFFF);   // R8 interrupt
    // R10: reset mid-run empties the queue, next start errors
    doReset();
    eCycle(2'b00, 2'b11, 16'h1234);
    eCycle(2'b11, 2'b10, 16'h5678);   // latch invalid -> tail invalid, head invalid -> error

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] mv, st;
      mv = 2'($urandom_range(0, 3));
      st = 2'($urandom_range(0, 3));
      eCycle(mv, st, 16'($urandom));
    end

    repeat (3 * HALF) @(negedge clk);
    // R1: every start on the pins produced exactly one event
    check("R1 pending events", expQ.size(), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule